// File: doc/BRIEF.md
# Up/Down Counter Register Field

This block is a single counting field of a register. It holds a count of parameterizable width. The count moves up when the increment input is high and down when the decrement input is high. If both inputs are high in one cycle, the two steps combine into one net update. Each direction uses its own step. The step is either a fixed parameter or a value taken from a step input of parameterizable width. Software may load the count directly at any time, and a load takes priority over counting in that cycle.

Each direction may have a saturation limit, chosen by a parameter. The limit may be absent, a fixed value, or a value taken from an input. A fixed ceiling of all ones is the full-scale limit, and a fixed floor of zero is the bottom limit. With a limit in place, the count never ends a cycle beyond it. This holds for counting, for software loads, for idle cycles after the limit input changes, and for the reset value. Without a limit, the count wraps modulo 2^WIDTH. In that case a combinational event output (wrap-up for increments, wrap-down for decrements) marks the cycle in which the wrap is about to happen.

Two threshold flags report the count against a per-direction level. The level may be absent, fixed, or taken from an input. The ceiling flag is high while count >= level. The floor flag is high while count <= level.

The field decides its update class every cycle. It uses three named classes: `OP_HOLD`, `OP_LOAD` and `OP_COUNT`. The transitions are these:
- any cycle with the software write high goes to `OP_LOAD`;
- otherwise, a cycle with increment or decrement high goes to `OP_COUNT`;
- every other cycle is `OP_HOLD`.

Top module: `updn_counter_field`

## Requirements
- R1: While `rst_n` is low, `count_o` equals `RESET_VAL` (default 0), and `wrap_up_o` and `wrap_dn_o` are 0.
- R2: In a cycle with `sw_we_i` low, the count updates by (increment step if `inc_i`) minus (decrement step if `dec_i`) as one update at the next clock edge. With neither input high, the count holds. A step of 0 leaves the count unchanged.
- R3: When a step parameter selects a fixed step, the count moves by the parameter value and ignores the matching step input. When it selects a dynamic step, the count moves by the step input value.
- R4: A cycle with `sw_we_i` high loads `sw_wdata_i`, subject to R7, and ignores `inc_i` and `dec_i` in that cycle.
- R5: With a ceiling limit, an update that would pass the limit ends at the limit. No `wrap_up_o` is raised, even when the raw sum exceeds 2^WIDTH-1.
- R6: With a floor limit, an update that would fall below the limit ends at the limit. No `wrap_dn_o` is raised, even when the raw result is below 0.
- R7: Limits also apply to software loads and to hold cycles. A loaded value above the ceiling becomes the ceiling, and a loaded value below the floor becomes the floor. After the dynamic ceiling is lowered, or after reset with a count outside the limits, the count moves to the limit at the next edge. If the limits conflict, the floor wins.
- R8: Without a ceiling limit, an increment whose result passes 2^WIDTH-1 raises `wrap_up_o` in that same cycle, and the count becomes the result modulo 2^WIDTH.
- R9: Without a floor limit, a decrement whose result falls below 0 raises `wrap_dn_o` in that same cycle, and the count becomes the result modulo 2^WIDTH.
- R10: `ge_flag_o` is 1 exactly while `count_o` >= the ceiling level. A fixed level of all ones is full scale.
- R11: `le_flag_o` is 1 exactly while `count_o` <= the floor level. A fixed level of 0 means the flag is set only at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_i | input | 1 | Count up this cycle |
| inc_step_i | input | STEP_W | Dynamic increment step |
| dec_i | input | 1 | Count down this cycle |
| dec_step_i | input | STEP_W | Dynamic decrement step |
| ceil_lim_i | input | WIDTH | Dynamic ceiling saturation limit |
| floor_lim_i | input | WIDTH | Dynamic floor saturation limit |
| ceil_lvl_i | input | WIDTH | Dynamic ceiling threshold level |
| floor_lvl_i | input | WIDTH | Dynamic floor threshold level |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | WIDTH | Software write value |
| count_o | output | WIDTH | Current count |
| wrap_up_o | output | 1 | Increment is about to wrap (combinational) |
| wrap_dn_o | output | 1 | Decrement is about to wrap (combinational) |
| ge_flag_o | output | 1 | Count >= ceiling level |
| le_flag_o | output | 1 | Count <= floor level |

## Verification
The assertions check several properties on every cycle:
- the count never ends a cycle outside the limits that held in the previous cycle;
- a load within limits lands exactly;
- an idle cycle changes nothing;
- a wrap event only comes from a counting cycle, and it moves the count in the direction that a modulo wrap implies.

The bench scenarios are needed for the exact arithmetic of combined steps and for fixed-step versus dynamic-step selection. They also cover the threshold boundaries at level and at level ±1, the clamp that follows a lowered dynamic ceiling, and the cycle in which each wrap event appears. A second instance without limits, with a fixed increment step and fixed full-scale/zero levels, covers the wrap paths.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    // How a limit or a threshold level is supplied
    typedef enum logic [1:0] {
        LIM_OFF     = 2'd0,
        LIM_STATIC  = 2'd1,
        LIM_DYNAMIC = 2'd2
    } lim_mode_e;

    // Update class chosen each cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2
    } op_e;

endpackage

// File: rtl/cnt_step_sel.sv
module cnt_step_sel #(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned STEP_W      = 4,
    parameter bit          DYN         = 1'b1,
    parameter int unsigned STATIC_STEP = 1
) (
    input  logic              en_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [WIDTH:0]    amt_o
);
    localparam int unsigned AW = WIDTH + 1;

    logic [AW-1:0] step_ext;

    generate
        if (DYN) begin : g_dyn
            assign step_ext = {{(AW-STEP_W){1'b0}}, step_i};
        end else begin : g_static
            logic step_unused;
            assign step_unused = ^step_i;
            assign step_ext    = AW'(STATIC_STEP);
        end
    endgenerate

    assign amt_o = en_i ? step_ext : '0;

endmodule

// File: rtl/cnt_limit_sel.sv
module cnt_limit_sel #(
    parameter int unsigned            WIDTH      = 8,
    parameter cnt_pkg::lim_mode_e     MODE       = cnt_pkg::LIM_DYNAMIC,
    parameter logic [WIDTH-1:0]       STATIC_VAL = '0
) (
    input  logic [WIDTH-1:0] dyn_i,
    output logic [WIDTH-1:0] val_o,
    output logic             on_o
);
    generate
        if (MODE == cnt_pkg::LIM_DYNAMIC) begin : g_dyn
            assign val_o = dyn_i;
            assign on_o  = 1'b1;
        end else if (MODE == cnt_pkg::LIM_STATIC) begin : g_static
            logic dyn_unused;
            assign dyn_unused = ^dyn_i;
            assign val_o      = STATIC_VAL;
            assign on_o       = 1'b1;
        end else begin : g_off
            logic dyn_unused;
            assign dyn_unused = ^dyn_i;
            assign val_o      = '0;
            assign on_o       = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/cnt_next_calc.sv
module cnt_next_calc #(
    parameter int unsigned WIDTH = 8
) (
    input  cnt_pkg::op_e     op_i,
    input  logic [WIDTH-1:0] count_i,
    input  logic [WIDTH:0]   inc_amt_i,
    input  logic [WIDTH:0]   dec_amt_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             ceil_on_i,
    input  logic [WIDTH-1:0] ceil_i,
    input  logic             floor_on_i,
    input  logic [WIDTH-1:0] floor_i,
    output logic [WIDTH-1:0] next_o,
    output logic             wrap_up_o,
    output logic             wrap_dn_o
);
    import cnt_pkg::*;

    localparam int unsigned EW = WIDTH + 2;

    logic [EW-1:0]    sum;
    logic             past_top;
    logic             below_zero;
    logic [WIDTH-1:0] cand;
    logic [WIDTH-1:0] clamped;

    // Signed-range sum: one sign bit and one carry bit above the count
    assign sum        = {2'b00, count_i} + {1'b0, inc_amt_i} - {1'b0, dec_amt_i};
    assign below_zero = sum[EW-1];
    assign past_top   = !sum[EW-1] && sum[WIDTH];

    always_comb begin
        cand      = count_i;
        wrap_up_o = 1'b0;
        wrap_dn_o = 1'b0;
        unique case (op_i)
            OP_HOLD: cand = count_i;
            OP_LOAD: cand = wdata_i;
            OP_COUNT: begin
                if (past_top && ceil_on_i) begin
                    cand = ceil_i;
                end else if (below_zero && floor_on_i) begin
                    cand = floor_i;
                end else begin
                    cand      = sum[WIDTH-1:0];
                    wrap_up_o = past_top;
                    wrap_dn_o = below_zero;
                end
            end
            default: cand = count_i;
        endcase
    end

    // Limits apply to every update class; the floor is applied last
    always_comb begin
        clamped = cand;
        if (ceil_on_i && (clamped > ceil_i)) begin
            clamped = ceil_i;
        end
        if (floor_on_i && (clamped < floor_i)) begin
            clamped = floor_i;
        end
    end

    assign next_o = clamped;

endmodule

// File: rtl/updn_counter_field.sv
module updn_counter_field #(
    parameter int unsigned        WIDTH          = 8,
    parameter int unsigned        STEP_W         = 4,
    parameter bit                 DEC_EN         = 1'b1,
    parameter bit                 INC_STEP_DYN   = 1'b1,
    parameter int unsigned        INC_STEP       = 1,
    parameter bit                 DEC_STEP_DYN   = 1'b1,
    parameter int unsigned        DEC_STEP       = 1,
    parameter cnt_pkg::lim_mode_e CEIL_SAT_MODE  = cnt_pkg::LIM_DYNAMIC,
    parameter logic [WIDTH-1:0]   CEIL_SAT_VAL   = '1,
    parameter cnt_pkg::lim_mode_e FLOOR_SAT_MODE = cnt_pkg::LIM_DYNAMIC,
    parameter logic [WIDTH-1:0]   FLOOR_SAT_VAL  = '0,
    parameter cnt_pkg::lim_mode_e CEIL_LVL_MODE  = cnt_pkg::LIM_DYNAMIC,
    parameter logic [WIDTH-1:0]   CEIL_LVL_VAL   = '1,
    parameter cnt_pkg::lim_mode_e FLOOR_LVL_MODE = cnt_pkg::LIM_DYNAMIC,
    parameter logic [WIDTH-1:0]   FLOOR_LVL_VAL  = '0,
    parameter logic [WIDTH-1:0]   RESET_VAL      = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic [STEP_W-1:0] inc_step_i,
    input  logic              dec_i,
    input  logic [STEP_W-1:0] dec_step_i,
    input  logic [WIDTH-1:0]  ceil_lim_i,
    input  logic [WIDTH-1:0]  floor_lim_i,
    input  logic [WIDTH-1:0]  ceil_lvl_i,
    input  logic [WIDTH-1:0]  floor_lvl_i,
    input  logic              sw_we_i,
    input  logic [WIDTH-1:0]  sw_wdata_i,
    output logic [WIDTH-1:0]  count_o,
    output logic              wrap_up_o,
    output logic              wrap_dn_o,
    output logic              ge_flag_o,
    output logic              le_flag_o
);
    import cnt_pkg::*;

    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] count_d;
    op_e              op;
    logic             dec_eff;
    logic [WIDTH:0]   inc_amt;
    logic [WIDTH:0]   dec_amt;
    logic [WIDTH-1:0] ceil_lim, floor_lim, ceil_lvl, floor_lvl;
    logic             ceil_on, floor_on, ceil_lvl_on, floor_lvl_on;

    // Down counting exists only when enabled by parameter
    generate
        if (DEC_EN) begin : g_dec
            assign dec_eff = dec_i;
        end else begin : g_no_dec
            logic dec_unused;
            assign dec_unused = dec_i;
            assign dec_eff    = 1'b0;
        end
    endgenerate

    // Update class selection: software write first, then counting
    always_comb begin
        if (sw_we_i) begin
            op = OP_LOAD;
        end else if (inc_i || dec_eff) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

    cnt_step_sel #(
        .WIDTH(WIDTH), .STEP_W(STEP_W), .DYN(INC_STEP_DYN), .STATIC_STEP(INC_STEP)
    ) u_inc_step (
        .en_i(inc_i), .step_i(inc_step_i), .amt_o(inc_amt)
    );

    cnt_step_sel #(
        .WIDTH(WIDTH), .STEP_W(STEP_W), .DYN(DEC_STEP_DYN), .STATIC_STEP(DEC_STEP)
    ) u_dec_step (
        .en_i(dec_eff), .step_i(dec_step_i), .amt_o(dec_amt)
    );

    cnt_limit_sel #(.WIDTH(WIDTH), .MODE(CEIL_SAT_MODE), .STATIC_VAL(CEIL_SAT_VAL))
        u_ceil_sat (.dyn_i(ceil_lim_i), .val_o(ceil_lim), .on_o(ceil_on));

    cnt_limit_sel #(.WIDTH(WIDTH), .MODE(FLOOR_SAT_MODE), .STATIC_VAL(FLOOR_SAT_VAL))
        u_floor_sat (.dyn_i(floor_lim_i), .val_o(floor_lim), .on_o(floor_on));

    cnt_limit_sel #(.WIDTH(WIDTH), .MODE(CEIL_LVL_MODE), .STATIC_VAL(CEIL_LVL_VAL))
        u_ceil_lvl (.dyn_i(ceil_lvl_i), .val_o(ceil_lvl), .on_o(ceil_lvl_on));

    cnt_limit_sel #(.WIDTH(WIDTH), .MODE(FLOOR_LVL_MODE), .STATIC_VAL(FLOOR_LVL_VAL))
        u_floor_lvl (.dyn_i(floor_lvl_i), .val_o(floor_lvl), .on_o(floor_lvl_on));

    cnt_next_calc #(.WIDTH(WIDTH)) u_next (
        .op_i       (op),
        .count_i    (count_q),
        .inc_amt_i  (inc_amt),
        .dec_amt_i  (dec_amt),
        .wdata_i    (sw_wdata_i),
        .ceil_on_i  (ceil_on),
        .ceil_i     (ceil_lim),
        .floor_on_i (floor_on),
        .floor_i    (floor_lim),
        .next_o     (count_d),
        .wrap_up_o  (wrap_up_o),
        .wrap_dn_o  (wrap_dn_o)
    );

    // Count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= RESET_VAL;
        end else begin
            count_q <= count_d;
        end
    end

    // Outputs
    always_comb begin
        count_o   = count_q;
        ge_flag_o = ceil_lvl_on && (count_q >= ceil_lvl);
        le_flag_o = floor_lvl_on && (count_q <= floor_lvl);
    end

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok_q <= 1'b0;
        end else begin
            past_ok_q <= 1'b1;
        end
    end

    // R5: count never ends above the ceiling that held last cycle
    a_r5_ceiling_bound: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(ceil_on && (!floor_on || floor_lim <= ceil_lim))
        |-> count_q <= $past(ceil_lim));

    // R6: count never ends below the floor that held last cycle
    a_r6_floor_bound: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(floor_on) |-> count_q >= $past(floor_lim));

    // R4: an in-range software write lands exactly
    a_r4_load_exact: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(sw_we_i && (!ceil_on || sw_wdata_i <= ceil_lim)
                                   && (!floor_on || sw_wdata_i >= floor_lim))
        |-> count_q == $past(sw_wdata_i));

    // R2: an idle cycle with an in-range count leaves it unchanged
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(!inc_i && !dec_i && !sw_we_i
                           && (!ceil_on || count_q <= ceil_lim)
                           && (!floor_on || count_q >= floor_lim))
        |-> count_q == $past(count_q));

    // R8: wrap-up only in a counting cycle with increment high
    a_r8_wrap_up_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_up_o |-> inc_i && !sw_we_i && !wrap_dn_o);

    // R8: a wrap-up leaves a smaller count
    a_r8_wrap_up_drop: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(wrap_up_o && !floor_on) |-> count_q < $past(count_q));

    // R9: wrap-down only in a counting cycle with decrement high
    a_r9_wrap_dn_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_dn_o |-> dec_i && !sw_we_i);

    // R9: a wrap-down leaves a larger count
    a_r9_wrap_dn_rise: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(wrap_dn_o && !ceil_on) |-> count_q > $past(count_q));

endmodule

// File: tb/updn_counter_field_tb.sv
`timescale 1ns/100ps
module updn_counter_field_tb;
    import cnt_pkg::*;

    localparam int W  = 8;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inc_i = 1'b0, dec_i = 1'b0, sw_we_i = 1'b0;
    logic [SW-1:0] inc_step_i = '0, dec_step_i = '0;
    logic [W-1:0]  sw_wdata_i = '0;
    logic [W-1:0]  ceil_lim = 8'd200, floor_lim = 8'd10;
    logic [W-1:0]  ceil_lvl = 8'd100, floor_lvl = 8'd20;

    logic [W-1:0]  cnt, w_cnt;
    logic          up, dn, ge, le, w_up, w_dn, w_ge, w_le;

    always #2 clk = ~clk;

    updn_counter_field #(.WIDTH(W), .STEP_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .inc_i(inc_i), .inc_step_i(inc_step_i),
        .dec_i(dec_i), .dec_step_i(dec_step_i),
        .ceil_lim_i(ceil_lim), .floor_lim_i(floor_lim),
        .ceil_lvl_i(ceil_lvl), .floor_lvl_i(floor_lvl),
        .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i),
        .count_o(cnt), .wrap_up_o(up), .wrap_dn_o(dn),
        .ge_flag_o(ge), .le_flag_o(le)
    );

    // No limits, fixed increment step 3, fixed full-scale / zero levels
    updn_counter_field #(
        .WIDTH(W), .STEP_W(SW),
        .INC_STEP_DYN(1'b0), .INC_STEP(3),
        .CEIL_SAT_MODE(LIM_OFF), .FLOOR_SAT_MODE(LIM_OFF),
        .CEIL_LVL_MODE(LIM_STATIC), .FLOOR_LVL_MODE(LIM_STATIC)
    ) u_dut_wrap (
        .clk(clk), .rst_n(rst_n),
        .inc_i(inc_i), .inc_step_i(inc_step_i),
        .dec_i(dec_i), .dec_step_i(dec_step_i),
        .ceil_lim_i(ceil_lim), .floor_lim_i(floor_lim),
        .ceil_lvl_i(ceil_lvl), .floor_lvl_i(floor_lvl),
        .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i),
        .count_o(w_cnt), .wrap_up_o(w_up), .wrap_dn_o(w_dn),
        .ge_flag_o(w_ge), .le_flag_o(w_le)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Inputs change at the falling edge
    task automatic drive(input logic we, input logic [W-1:0] wd,
                         input logic inc, input logic [SW-1:0] is,
                         input logic dec, input logic [SW-1:0] ds);
        @(negedge clk);
        sw_we_i = we; sw_wdata_i = wd;
        inc_i = inc; inc_step_i = is;
        dec_i = dec; dec_step_i = ds;
        #0.5;
    endtask

    task automatic tick();
        @(posedge clk);
        #0.5;
    endtask

    typedef struct packed {
        logic          we;
        logic [W-1:0]  wd;
        logic          inc;
        logic [SW-1:0] is;
        logic          dec;
        logic [SW-1:0] ds;
        logic [W-1:0]  exp;
    } vec_t;

    // Ceiling limit 200, floor limit 10, starting from reset value 0
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd0,   1'b0, 4'd0,  1'b0, 4'd0,  8'd10 },  // R7 reset value raised to floor
        '{1'b0, 8'd0,   1'b1, 4'd5,  1'b0, 4'd0,  8'd15 },  // R2
        '{1'b0, 8'd0,   1'b1, 4'd15, 1'b0, 4'd0,  8'd30 },  // R3 dynamic step
        '{1'b0, 8'd0,   1'b0, 4'd0,  1'b1, 4'd7,  8'd23 },  // R2
        '{1'b0, 8'd0,   1'b1, 4'd9,  1'b1, 4'd4,  8'd28 },  // R2 net
        '{1'b1, 8'd150, 1'b0, 4'd0,  1'b0, 4'd0,  8'd150},  // R4
        '{1'b1, 8'd50,  1'b1, 4'd5,  1'b0, 4'd0,  8'd50 },  // R4 priority
        '{1'b0, 8'd0,   1'b1, 4'd15, 1'b0, 4'd0,  8'd65 },  // R2
        '{1'b1, 8'd250, 1'b0, 4'd0,  1'b0, 4'd0,  8'd200},  // R7 load clamp
        '{1'b0, 8'd0,   1'b1, 4'd15, 1'b0, 4'd0,  8'd200},  // R5
        '{1'b1, 8'd5,   1'b0, 4'd0,  1'b0, 4'd0,  8'd10 },  // R7 load clamp
        '{1'b0, 8'd0,   1'b0, 4'd0,  1'b1, 4'd15, 8'd10 },  // R6 below zero
        '{1'b1, 8'd12,  1'b0, 4'd0,  1'b0, 4'd0,  8'd12 },  // R4
        '{1'b0, 8'd0,   1'b0, 4'd0,  1'b1, 4'd3,  8'd10 },  // R6
        '{1'b0, 8'd0,   1'b1, 4'd0,  1'b0, 4'd0,  8'd10 },  // R2 zero step
        '{1'b1, 8'd40,  1'b0, 4'd0,  1'b0, 4'd0,  8'd40 },  // R4
        '{1'b0, 8'd0,   1'b1, 4'd4,  1'b1, 4'd4,  8'd40 },  // R2 net zero
        '{1'b0, 8'd0,   1'b1, 4'd3,  1'b1, 4'd9,  8'd34 }   // R2 net down
    };

    logic finished = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 count in reset", cnt, 0);
        chk("R1 wrap_up in reset", up, 0);
        chk("R1 wrap_dn in reset", dn, 0);
        chk("R11 le flag at 0 vs level 20", le, 1);
        rst_n = 1'b1;

        // Table walk
        foreach (VECS[i]) begin
            drive(VECS[i].we, VECS[i].wd, VECS[i].inc, VECS[i].is,
                  VECS[i].dec, VECS[i].ds);
            chk($sformatf("R5 no wrap_up with ceiling, vec %0d", i), up, 0);
            chk($sformatf("R6 no wrap_dn with floor, vec %0d", i), dn, 0);
            tick();
            chk($sformatf("R2/R4/R7 count, vec %0d", i), cnt, VECS[i].exp);
        end

        // R7 lowering the dynamic ceiling clamps on a hold cycle
        drive(1'b1, 8'd150, 1'b0, 4'd0, 1'b0, 4'd0); tick();
        drive(1'b0, 8'd0,   1'b0, 4'd0, 1'b0, 4'd0);
        ceil_lim = 8'd120;
        tick();
        chk("R7 hold clamp to lowered ceiling", cnt, 120);
        ceil_lim = 8'd200;

        // R10 / R11 dynamic thresholds (ceiling level 100, floor level 20)
        drive(1'b1, 8'd100, 1'b0, 4'd0, 1'b0, 4'd0); tick();
        chk("R10 ge at level", ge, 1);
        drive(1'b1, 8'd99,  1'b0, 4'd0, 1'b0, 4'd0); tick();
        chk("R10 ge below level", ge, 0);
        drive(1'b1, 8'd20,  1'b0, 4'd0, 1'b0, 4'd0); tick();
        chk("R11 le at level", le, 1);
        drive(1'b1, 8'd21,  1'b0, 4'd0, 1'b0, 4'd0); tick();
        chk("R11 le above level", le, 0);

        // R8 wrap on the limitless instance, fixed step 3
        drive(1'b1, 8'd254, 1'b0, 4'd0, 1'b0, 4'd0); tick();
        chk("R4 wrap instance load", w_cnt, 254);
        drive(1'b0, 8'd0, 1'b1, 4'd15, 1'b0, 4'd0);
        chk("R8 wrap_up in wrapping cycle", w_up, 1);
        chk("R8 no wrap_dn on increment", w_dn, 0);
        tick();
        chk("R8 count wrapped", w_cnt, 1);
        drive(1'b0, 8'd0, 1'b0, 4'd0, 1'b0, 4'd0);
        chk("R8 wrap_up is a pulse", w_up, 0);

        // R3 fixed step ignores the step input
        drive(1'b1, 8'd10, 1'b0, 4'd0, 1'b0, 4'd0); tick();
        drive(1'b0, 8'd0, 1'b1, 4'd15, 1'b0, 4'd0); tick();
        chk("R3 fixed step 3 ignores input 15", w_cnt, 13);

        // R9 wrap below zero
        drive(1'b1, 8'd2, 1'b0, 4'd0, 1'b0, 4'd0); tick();
        drive(1'b0, 8'd0, 1'b0, 4'd0, 1'b1, 4'd5);
        chk("R9 wrap_dn in wrapping cycle", w_dn, 1);
        chk("R9 no wrap_up on decrement", w_up, 0);
        tick();
        chk("R9 count wrapped", w_cnt, 253);

        // R10 / R11 fixed full-scale and zero levels
        drive(1'b1, 8'd255, 1'b0, 4'd0, 1'b0, 4'd0); tick();
        chk("R10 fixed level ge at full scale", w_ge, 1);
        chk("R11 fixed level le at full scale", w_le, 0);
        drive(1'b1, 8'd254, 1'b0, 4'd0, 1'b0, 4'd0); tick();
        chk("R10 fixed level ge below full scale", w_ge, 0);
        drive(1'b1, 8'd0, 1'b0, 4'd0, 1'b0, 4'd0); tick();
        chk("R11 fixed level le at zero", w_le, 1);
        chk("R10 fixed level ge at zero", w_ge, 0);
        drive(1'b1, 8'd1, 1'b0, 4'd0, 1'b0, 4'd0); tick();
        chk("R11 fixed level le at one", w_le, 0);

        drive(1'b0, 8'd0, 1'b0, 4'd0, 1'b0, 4'd0); tick();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule